// File: doc/BRIEF.md
# I2C Master Transfer Engine with Word-Packed Data

This block is an I2C bus master for a 32-bit processor register bus. Software programs a transfer descriptor with a 7-bit target address, a direction bit and a byte count. The engine then sends a START condition and the address byte. For a write it sends the data bytes. For a read it collects them. It handles the acknowledge bit after every byte and ends with a STOP condition. Data passes through a single 32-bit word register. On transmit the word is unpacked into bytes, most significant byte first. On receive the incoming bytes are packed into the word from the most significant end downward.

During transmit, the byte count goes down when a byte is copied from the word into the shift register, not when that byte leaves on the wire. Software is therefore told early when the word is used up, and can write the next word while the last byte of the old one is still going out. If no new word has arrived by the next byte boundary, the engine holds SCL low until one does. A status register reports four sticky event flags. Each flag has its own interrupt enable and its own write-one-to-clear bit. The status register also shows the live line levels, the direction, a busy bit and the engine state. A software mode lets software drive the two lines directly.

Top module: `i2c_word_master`

## Requirements
- R1: After reset, both open-drain enables are low, `irq` is low, the descriptor (index 0) and control (index 3) registers read 0, and status (index 2) reads 0x30 with both lines idle high.
- R2: In write mode (descriptor bit 8 = 0, enable on), a write to the data register (index 1) starts a transfer. The wire carries START, then the byte {address from descriptor bits 15:9, 0}, then the data bytes from bits 31:24 down to bits 7:0.
- R3: The count field (descriptor bits 7:0) goes down by one for each data byte and can be read at any time. In write mode the decrement happens when the byte is loaded, ahead of its shifting. A count of 0 sends only the address byte and then STOP.
- R4: In write mode, when the fourth byte of a word is loaded and count remains, status bit 0 (data) is set. If the next byte is needed before a new word is written, SCL is held low. The next data write resumes the transfer. A word that ends the count does not set bit 0.
- R5: Writing the descriptor with bit 8 = 1 while enabled starts a read with the address byte {address, 1}. Received bytes fill data bits 31:24 first, and a fresh word starts with its lower bytes cleared. Status bit 0 is set when four bytes have been packed or the last byte arrives.
- R6: In read mode the master acknowledges every byte except the last, which it NACKs before STOP.
- R7: A NACK on the address byte ends the transfer with STOP, sets status bit 2, leaves the count unchanged and does not set the done flag.
- R8: A NACK on a written data byte ends the transfer with STOP, sets status bit 3 and does not set the done flag.
- R9: Normal completion sets status bit 1. Control bits 11:8 clear flags 0 to 3 when written as 1. `irq` is high when any flag is set whose enable (control bits 7:4, same order) is set.
- R10: SCL stays high for exactly 2×QUARTER clocks in every bit. Inside a transfer, SDA changes only while SCL is low, except at START and STOP.
- R11: With control bit 1 set, control bits 2 and 3 set the SDA and SCL line levels (0 = pull low). Status bits 4 and 5 show the live SDA and SCL levels.
- R12: Descriptor writes made while a transfer is busy are ignored. With enable (control bit 0) clear, no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index: 0 descriptor, 1 data, 2 status, 3 control |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets the early decrement: it reads the count at the moment the word-empty flag rises, while the last byte of that word is still queued on the wire. An engine that counted on the wire would read one higher there. It would also fail to stall with SCL low, or would set the flag after a word that ends the transfer. In read mode it checks that the next word clears its lower bytes, and it counts acknowledge versus NACK bits, which catches an engine that acknowledges the last byte. Address and data NACK runs check that the transfer aborts with the count left untouched or decremented, and that no done flag is set. A monitor measures the SCL high time and counts START conditions, so an SDA edge during a high phase shows up as a spurious START.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BIT   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_STOP  = 3'd4
  } eng_st_e;

  localparam logic [1:0] RA_DESC = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;

  localparam int FLG_DATA  = 0;
  localparam int FLG_DONE  = 1;
  localparam int FLG_ANACK = 2;
  localparam int FLG_DNACK = 3;
  localparam int NUM_FLG   = 4;
endpackage

// File: rtl/i2cw_tick_gen.sv
module i2cw_tick_gen #(
  parameter int QUARTER = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int QW = (QUARTER > 2) ? $clog2(QUARTER) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUARTER - 1);

  logic [QW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       rx_mode,
  input  logic [6:0] slave_addr,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  input  logic       word_ok,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       take,
  output logic       rx_stb,
  output logic [7:0] rx_byte,
  output logic       done_stb,
  output logic       anack_stb,
  output logic       dnack_stb,
  output logic       busy,
  output eng_st_e    state
);
  eng_st_e    st_q, st_d;
  logic [1:0] q_q, q_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       adr_q, adr_d;
  logic       ack_q, ack_d;
  logic       drv_q, drv_d;
  logic       abort_q, abort_d;
  logic       master_tx;

  assign master_tx = adr_q || !rx_mode;

  always_comb begin
    st_d = st_q; q_d = q_q; bit_d = bit_q; sh_d = sh_q;
    adr_d = adr_q; ack_d = ack_q; drv_d = drv_q; abort_d = abort_q;
    take = 1'b0; rx_stb = 1'b0; done_stb = 1'b0;
    anack_stb = 1'b0; dnack_stb = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        drv_d   = 1'b0;
        abort_d = 1'b0;
        if (go && tick) begin st_d = ST_START; q_d = 2'd0; end
      end
      ST_START: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd1) drv_d = 1'b1;
        if (q_q == 2'd3) begin
          st_d = ST_BIT; bit_d = 4'd0; adr_d = 1'b1;
          sh_d = {slave_addr, rx_mode};
        end
      end
      ST_BIT: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd0) begin
          if (bit_q < 4'd8) drv_d = master_tx ? ~sh_q[7] : 1'b0;
          else              drv_d = master_tx ? 1'b0 : ~cnt_one;
        end
        if (q_q == 2'd2) begin
          if (bit_q < 4'd8) sh_d = {sh_q[6:0], sda_in};
          else              ack_d = sda_in;
        end
        if (q_q == 2'd3) begin
          if (bit_q != 4'd8) bit_d = bit_q + 4'd1;
          else begin
            bit_d = 4'd0;
            if (master_tx) begin
              if (ack_q) begin
                st_d = ST_STOP; abort_d = 1'b1;
                if (adr_q) anack_stb = 1'b1;
                else       dnack_stb = 1'b1;
              end else if (cnt_zero) st_d = ST_STOP;
              else begin
                adr_d = 1'b0;
                if (!rx_mode) begin
                  if (word_ok) begin take = 1'b1; sh_d = tx_byte; end
                  else st_d = ST_WAIT;
                end
              end
            end else begin
              rx_stb = 1'b1;
              if (cnt_one) st_d = ST_STOP;
            end
          end
        end
      end
      ST_WAIT: if (word_ok && tick) begin
        take = 1'b1; sh_d = tx_byte;
        st_d = ST_BIT; q_d = 2'd0; bit_d = 4'd0;
      end
      ST_STOP: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd0) drv_d = 1'b1;
        if (q_q == 2'd2) drv_d = 1'b0;
        if (q_q == 2'd3) begin st_d = ST_IDLE; done_stb = !abort_q; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; q_q <= 2'd0; bit_q <= 4'd0; sh_q <= 8'd0;
      adr_q <= 1'b0; ack_q <= 1'b0; drv_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      st_q <= st_d; q_q <= q_d; bit_q <= bit_d; sh_q <= sh_d;
      adr_q <= adr_d; ack_q <= ack_d; drv_q <= drv_d; abort_q <= abort_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_BIT:  scl_oe = !q_q[1];
      ST_WAIT: scl_oe = 1'b1;
      ST_STOP: scl_oe = (q_q == 2'd0);
      default: scl_oe = 1'b0;
    endcase
  end

  assign sda_oe  = drv_q;
  assign rx_byte = sh_q;
  assign busy    = (st_q != ST_IDLE);
  assign state   = st_q;

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && st_q == ST_BIT && $past(st_q) == ST_BIT) |-> (scl_oe && $past(scl_oe))); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, rx_stb, done_stb, anack_stb, dnack_stb})); // R9
endmodule

// File: rtl/i2c_word_master.sv
module i2c_word_master
  import i2cw_pkg::*;
#(
  parameter int QUARTER = 4,
  parameter int CNT_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int DIR_B   = CNT_W;
  localparam int ADDR_LO = CNT_W + 1;
  localparam int PAD_W   = 32 - CNT_W - 8;

  logic rs1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs1_q <= 1'b0; srst_n <= 1'b0; end
    else        begin rs1_q <= 1'b1; srst_n <= rs1_q; end
  end

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dir_q, dir_d;
  logic [6:0]         sadr_q, sadr_d;
  logic [31:0]        wrd_q, wrd_d;
  logic [1:0]         bp_q, bp_d;
  logic               wok_q, wok_d, pend_q, pend_d;
  logic [7:0]         ctl_q, ctl_d;
  logic [NUM_FLG-1:0] flg_q, flg_d, flg_set, flg_clr;
  logic               data_ev;

  logic       tick, take, rx_stb, done_stb, anack_stb, dnack_stb, busy;
  logic       e_scl, e_sda;
  logic [7:0] rx_byte, tx_byte;
  eng_st_e    e_state;

  logic en, sw, idle, wr_desc, wr_data, wr_ctrl;
  assign en      = ctl_q[0];
  assign sw      = ctl_q[1];
  assign idle    = !busy && !pend_q;
  assign wr_desc = bus_wr && (bus_addr == RA_DESC);
  assign wr_data = bus_wr && (bus_addr == RA_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);

  i2cw_tick_gen #(.QUARTER(QUARTER)) u_tick (.clk(clk), .rst_n(srst_n), .tick(tick));

  i2cw_engine u_eng (
    .clk(clk), .rst_n(srst_n), .tick(tick), .go(pend_q), .rx_mode(dir_q),
    .slave_addr(sadr_q), .cnt_zero(cnt_q == '0), .cnt_one(cnt_q == CNT_W'(1)),
    .word_ok(wok_q), .tx_byte(tx_byte), .sda_in(sda_in),
    .scl_oe(e_scl), .sda_oe(e_sda), .take(take), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .done_stb(done_stb), .anack_stb(anack_stb), .dnack_stb(dnack_stb),
    .busy(busy), .state(e_state)
  );

  always_comb begin
    unique case (bp_q)
      2'd0:    tx_byte = wrd_q[31:24];
      2'd1:    tx_byte = wrd_q[23:16];
      2'd2:    tx_byte = wrd_q[15:8];
      default: tx_byte = wrd_q[7:0];
    endcase
  end

  always_comb begin
    cnt_d = cnt_q; dir_d = dir_q; sadr_d = sadr_q; wrd_d = wrd_q;
    bp_d = bp_q; wok_d = wok_q; pend_d = pend_q; ctl_d = ctl_q;
    data_ev = 1'b0;
    if (busy) pend_d = 1'b0;
    if (wr_desc && idle) begin
      cnt_d  = bus_wdata[CNT_W-1:0];
      dir_d  = bus_wdata[DIR_B];
      sadr_d = bus_wdata[ADDR_LO +: 7];
      if (bus_wdata[DIR_B] && en) begin pend_d = 1'b1; bp_d = 2'd0; wrd_d = '0; end
    end
    if (take) begin
      cnt_d = cnt_q - 1'b1;
      bp_d  = bp_q + 2'd1;
      if (bp_q == 2'd3) begin wok_d = 1'b0; data_ev = (cnt_q != CNT_W'(1)); end
    end
    if (rx_stb) begin
      cnt_d = cnt_q - 1'b1;
      bp_d  = bp_q + 2'd1;
      unique case (bp_q)
        2'd0:    wrd_d = {rx_byte, 24'd0};
        2'd1:    wrd_d[23:16] = rx_byte;
        2'd2:    wrd_d[15:8]  = rx_byte;
        default: wrd_d[7:0]   = rx_byte;
      endcase
      data_ev = (bp_q == 2'd3) || (cnt_q == CNT_W'(1));
    end
    if (wr_data) begin
      wrd_d = bus_wdata; bp_d = 2'd0; wok_d = 1'b1;
      if (idle && !dir_q && en) pend_d = 1'b1;
    end
    if (wr_ctrl) ctl_d = bus_wdata[7:0];
  end

  assign flg_set = {dnack_stb, anack_stb, done_stb, data_ev};
  assign flg_clr = wr_ctrl ? bus_wdata[11:8] : '0;

  for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
    always_comb flg_d[i] = flg_set[i] | (flg_q[i] & !flg_clr[i]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0; dir_q <= 1'b0; sadr_q <= '0; wrd_q <= '0; bp_q <= 2'd0;
      wok_q <= 1'b0; pend_q <= 1'b0; ctl_q <= '0; flg_q <= '0;
    end else begin
      cnt_q <= cnt_d; dir_q <= dir_d; sadr_q <= sadr_d; wrd_q <= wrd_d; bp_q <= bp_d;
      wok_q <= wok_d; pend_q <= pend_d; ctl_q <= ctl_d; flg_q <= flg_d;
    end
  end

  assign scl_oe = sw ? !ctl_q[3] : e_scl;
  assign sda_oe = sw ? !ctl_q[2] : e_sda;
  assign irq    = |(flg_q & ctl_q[7:4]);

  always_comb begin
    unique case (bus_addr)
      RA_DESC: bus_rdata = {{PAD_W{1'b0}}, sadr_q, dir_q, cnt_q};
      RA_DATA: bus_rdata = wrd_q;
      RA_STAT: bus_rdata = {21'd0, e_state, busy, dir_q, scl_in, sda_in, flg_q};
      default: bus_rdata = {24'd0, ctl_q};
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && $past(busy)) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_TAKE_HAS_WORD: assert property (@(posedge clk) disable iff (!srst_n)
    take |-> (wok_q && cnt_q != '0)); // R4
endmodule

// File: tb/i2c_word_master_test.sv
`timescale 1ns/1ps
module i2c_word_master_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, bus_wr, irq, scl_oe, sda_oe, s_pull;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        scl_line, sda_line;
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_pull);

  i2c_word_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor and target model
  logic pscl = 1'b1, psda = 1'b1, in_frame = 1'b0, adr_ph = 1'b0, rd_mode = 1'b0;
  logic tracking = 1'b0, mack_last = 1'b0, ack_addr = 1'b1, ack_data = 1'b1;
  logic [7:0] sh = 8'd0, rd_sh = 8'd0;
  int rc = 0, hi_cnt = 0, n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;

  always @(negedge clk) begin
    if (scl_line && pscl && psda && !sda_line) begin
      n_start++; in_frame = 1'b1; rc = 0; adr_ph = 1'b1; rd_mode = 1'b0;
      s_pull = 1'b0; tracking = 1'b0;
    end else if (scl_line && pscl && !psda && sda_line) begin
      n_stop++; in_frame = 1'b0; s_pull = 1'b0; tracking = 1'b0;
    end else if (in_frame) begin
      if (scl_line && !pscl) begin
        tracking = 1'b1; hi_cnt = 0; rc++;
        if (rc <= 8) sh = {sh[6:0], sda_line};
        if (rc == 9 && rd_mode && !adr_ph) begin
          mack_last = !sda_line;
          if (!sda_line) n_mack++; else n_mnack++;
        end
      end
      if (!scl_line && pscl) begin
        if (tracking) chk("R10 scl high time", hi_cnt, 8);
        if (rc == 8) begin
          if (adr_ph || !rd_mode) begin
            if (adr_ph) rd_mode = sh[0];
            if (exp_q.size() > 0) chk("R2 byte on wire", {24'd0, sh}, {24'd0, exp_q.pop_front()});
            else chk("R2 unexpected byte", 1, 0);
            s_pull = adr_ph ? ack_addr : ack_data;
          end else s_pull = 1'b0;
        end else if (rc == 9) begin
          rc = 0; s_pull = 1'b0;
          if (rd_mode && (adr_ph ? ack_addr : mack_last) && rd_q.size() > 0) begin
            rd_sh = rd_q.pop_front(); s_pull = ~rd_sh[7];
          end
          adr_ph = 1'b0;
        end else if (rd_mode && !adr_ph && rc >= 1 && rc <= 7) s_pull = ~rd_sh[7-rc];
      end
      if (scl_line) hi_cnt++;
    end
    pscl = scl_line; psda = sda_line;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_flag(input int b, input string tag);
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      rd(2'd2, s);
      if (s[b]) return;
    end
    chk({tag, " flag timeout"}, 0, 1);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] v;
    int s0, p0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0; s_pull = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0); chk("R1 irq", irq, 0);
    rd(2'd2, v); chk("R1 status", v, 32'h30);
    rd(2'd0, v); chk("R1 descriptor", v, 0);
    rd(2'd3, v); chk("R1 control", v, 0);

    // R12 enable off: nothing starts
    s0 = n_start;
    wr(2'd0, {16'd0, 7'h5A, 1'b0, 8'd2});
    wr(2'd1, 32'h01020304);
    idle_wait(200);
    chk("R12 no start when disabled", n_start, s0);
    rd(2'd2, v); chk("R12 not busy when disabled", v[7], 0);

    // R2 R3 R4 two-word write, 6 bytes
    wr(2'd3, 32'h0000_0001);
    s0 = n_start; p0 = n_stop;
    wr(2'd0, {16'd0, 7'h5A, 1'b0, 8'd6});
    rd(2'd0, v); chk("R3 count readable", v[7:0], 6);
    exp_q.push_back(8'hB4);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    exp_q.push_back(8'hA1); exp_q.push_back(8'hB2);
    wr(2'd1, 32'h11223344);
    wait_flag(0, "R4");
    rd(2'd0, v); chk("R3 count drops ahead of shift", v[7:0], 2);
    chk("R3 last byte of word still queued", exp_q.size(), 3);
    idle_wait(400);
    chk("R4 scl held low while starved", scl_line, 0);
    chk("R4 starved after last byte", exp_q.size(), 2);
    wr(2'd0, {16'd0, 7'h11, 1'b0, 8'd9});
    rd(2'd0, v); chk("R12 descriptor ignored while busy", v[15:0], {7'h5A, 1'b0, 8'd2});
    wr(2'd3, 32'h0000_00F1);
    @(negedge clk); chk("R9 irq on enabled flag", irq, 1);
    wr(2'd3, 32'h0000_01F1);
    @(negedge clk); chk("R9 irq after clear", irq, 0);
    wr(2'd1, 32'hA1B2C3D4);
    wait_flag(1, "R9 done");
    idle_wait(20);
    chk("R2 all bytes sent", exp_q.size(), 0);
    rd(2'd0, v); chk("R3 count at end", v[7:0], 0);
    rd(2'd2, v); chk("R4 no flag on final word", v[0], 0);
    chk("R10 single start", n_start - s0, 1);
    chk("R2 single stop", n_stop - p0, 1);
    wr(2'd3, 32'h0000_0F01);

    // R3 count zero: address only
    exp_q.push_back(8'h66);
    wr(2'd0, {16'd0, 7'h33, 1'b0, 8'd0});
    wr(2'd1, 32'hFFFFFFFF);
    wait_flag(1, "R3 zero count");
    idle_wait(20);
    chk("R3 zero count sends address only", exp_q.size(), 0);
    wr(2'd3, 32'h0000_0F01);

    // R5 R6 read of 5 bytes
    n_mack = 0; n_mnack = 0; p0 = n_stop;
    rd_q.push_back(8'h9A); rd_q.push_back(8'h00); rd_q.push_back(8'hFF);
    rd_q.push_back(8'h5C); rd_q.push_back(8'h81);
    exp_q.push_back(8'h79);
    wr(2'd0, {16'd0, 7'h3C, 1'b1, 8'd5});
    wait_flag(0, "R5 word");
    rd(2'd1, v); chk("R5 packed word", v, 32'h9A00FF5C);
    wr(2'd3, 32'h0000_0101);
    wait_flag(1, "R5 done");
    idle_wait(20);
    rd(2'd1, v); chk("R5 partial word", v, 32'h81000000);
    rd(2'd2, v); chk("R5 flag on last byte", v[0], 1);
    chk("R6 acks", n_mack, 4); chk("R6 final nack", n_mnack, 1);
    chk("R6 stop after read", n_stop - p0, 1);
    wr(2'd3, 32'h0000_0F01);

    // R7 address NACK
    ack_addr = 1'b0; p0 = n_stop;
    exp_q.push_back(8'h5A);
    wr(2'd0, {16'd0, 7'h2D, 1'b0, 8'd2});
    wr(2'd1, 32'h01020304);
    wait_flag(2, "R7");
    idle_wait(30);
    rd(2'd2, v); chk("R7 no done, idle", {v[7], v[1]}, 0);
    rd(2'd0, v); chk("R7 count kept", v[7:0], 2);
    chk("R7 stop issued", n_stop - p0, 1);
    chk("R7 only address sent", exp_q.size(), 0);
    ack_addr = 1'b1;
    wr(2'd3, 32'h0000_0F01);

    // R8 data NACK
    ack_data = 1'b0; p0 = n_stop;
    exp_q.push_back(8'h5A); exp_q.push_back(8'hDE);
    wr(2'd0, {16'd0, 7'h2D, 1'b0, 8'd3});
    wr(2'd1, 32'hDEADBEEF);
    wait_flag(3, "R8");
    idle_wait(30);
    rd(2'd2, v); chk("R8 no done, idle", {v[7], v[1]}, 0);
    rd(2'd0, v); chk("R8 count after abort", v[7:0], 2);
    chk("R8 stop issued", n_stop - p0, 1);
    chk("R8 abort after first byte", exp_q.size(), 0);
    ack_data = 1'b1;
    @(negedge clk); chk("R9 irq masked", irq, 0);
    wr(2'd3, 32'h0000_0081);
    @(negedge clk); chk("R9 irq data nack enabled", irq, 1);
    wr(2'd3, 32'h0000_0F01);

    // R11 software line control
    wr(2'd3, 32'h0000_000B);
    @(negedge clk); chk("R11 sda driven", {scl_oe, sda_oe}, 2'b01);
    rd(2'd2, v); chk("R11 live levels", v[5:4], 2'b10);
    wr(2'd3, 32'h0000_0007);
    rd(2'd2, v); chk("R11 scl low", v[5:4], 2'b01);
    wr(2'd3, 32'h0000_000F);
    rd(2'd2, v); chk("R11 released", v[5:4], 2'b11);

    report();
  end
endmodule